// File: doc/BRIEF.md
# Instruction Fill Load Predecoder

This block sits on the refill path of an instruction cache. When a missed line arrives, it examines every instruction slot of that line once. For each slot that holds a load, it builds a compact record holding four things: whether the slot is a load, how the load forms its address, which class of base register it uses, and its constant offset. The records are written into a side array next to the line. On later fetches of that line, the load pipes read the records directly. They can then pick out and steer loads without decoding the instruction words again, so finding and aligning loads finishes within the fetch stage. Cache hits never pass through this block.

A small two-state controller sequences the write. In `ST_IDLE` the controller waits for the fill strobe. A fill moves it to `ST_WRITE` (transition IDLE→WRITE). In `ST_WRITE` the registered records are presented together with the array write enable. From `ST_WRITE`, the controller stays in `ST_WRITE` if another fill arrives at once (WRITE→WRITE). Otherwise it returns to idle (WRITE→IDLE). With no fill, idle stays idle (IDLE→IDLE).

Instruction slot `i` of the line occupies bits `[32*i+31 : 32*i]`. Within a word, the major opcode is bits `[31:26]`, the base register number is bits `[25:21]`, the immediate is bits `[15:0]`, and the minor function code is bits `[5:0]`.

Top module: `lpd_fill_predecoder`

## Requirements
- R1: After reset, `rec_we` is 0 and every record output (`rec_valid`, `rec_mode`, `rec_btype`, `rec_offset`) is all zero.
- R2: `rec_we` is 1 in exactly those cycles that directly follow a cycle with `fill_valid` high. Back-to-back fills keep it high, and it is 0 in every other cycle.
- R3: A slot whose opcode bits `[31:26]` have their top three bits equal to `3'b100` is a register-plus-constant load. It gives `rec_valid`=1 and `rec_mode`=0.
- R4: A slot whose opcode is `6'h1F` and whose function bits `[5:3]` equal `3'b001` is a register-plus-register load. It gives `rec_valid`=1, `rec_mode`=1 and an offset of zero.
- R5: For a load, `rec_btype` is 2'b01 when base field `[25:21]` is 29 (stack pointer), 2'b10 when it is 28 (global pointer), and 2'b00 otherwise. The value 2'b11 never appears.
- R6: For a register-plus-constant load, `rec_offset` is bits `[15:0]` sign-extended to 32 bits.
- R7: A slot that is not a load produces an all-zero record: valid 0, mode 0, class 0, offset 0.
- R8: Record outputs change only in the cycle after a fill. With `fill_valid` low they hold their values, whatever `fill_line` carries.
- R9: Each slot is decoded only from its own 32-bit field. A record depends on nothing in other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Refill line present this cycle |
| fill_line | input | SLOTS*32 | Refill instruction words, slot 0 in the low bits |
| rec_we | output | 1 | Write enable toward the predecode array |
| rec_valid | output | SLOTS | Per-slot load flag |
| rec_mode | output | SLOTS | Per-slot addressing mode (0 reg+const, 1 reg+reg) |
| rec_btype | output | SLOTS*2 | Per-slot base-register class |
| rec_offset | output | SLOTS*32 | Per-slot sign-extended offset |

## Verification
The bench sweeps every one of the 64 major opcodes against every base register number, and every function code under the indexed opcode. This exposes a decoder that accepts a neighbouring opcode, or that misses the indexed form, at the exact boundary values. Base numbers 28, 29 and their neighbours catch a swapped or off-by-one pointer classification. Immediates with the sign bit set catch a zero-extended offset, and an indexed load given a non-zero low half catches an offset that leaks through. A placement test with the same load in each slot, non-loads in the other slots, and idle cycles carrying junk lines catches records that are recomputed without a fill, a write enable that stays high or is skipped on back-to-back fills, and a slot that reads its neighbour's word.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

    localparam int LPD_IW    = 32;
    localparam int LPD_OFS_W = 32;
    localparam int LPD_IMM_W = 16;
    localparam int LPD_REG_W = 5;

    localparam logic [2:0] LPD_OP_IMM_HI = 3'b100;
    localparam logic [5:0] LPD_OP_IDX    = 6'h1F;
    localparam logic [2:0] LPD_FN_IDX_HI = 3'b001;

    typedef enum logic {
        MODE_REG_IMM = 1'b0,
        MODE_REG_REG = 1'b1
    } lpd_mode_e;

    typedef enum logic [1:0] {
        BASE_OTHER = 2'b00,
        BASE_SP    = 2'b01,
        BASE_GP    = 2'b10
    } lpd_base_e;

    typedef struct packed {
        logic                 valid;
        lpd_mode_e            mode;
        lpd_base_e            base;
        logic [LPD_OFS_W-1:0] offset;
    } lpd_rec_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } lpd_state_e;

endpackage

// File: rtl/lpd_slot_decode.sv
module lpd_slot_decode
    import lpd_pkg::*;
#(
    parameter int SP_REG = 29,
    parameter int GP_REG = 28
) (
    input  logic [LPD_IW-1:0] instr,
    output lpd_rec_t          rec
);

    localparam logic [LPD_REG_W-1:0] SP_NUM = LPD_REG_W'(SP_REG);
    localparam logic [LPD_REG_W-1:0] GP_NUM = LPD_REG_W'(GP_REG);

    logic [5:0]           op_f;
    logic [LPD_REG_W-1:0] base_f;
    logic [LPD_IMM_W-1:0] imm_f;
    logic                 is_imm;
    logic                 is_idx;

    always_comb begin
        op_f   = instr[31:26];
        base_f = instr[25:21];
        imm_f  = instr[LPD_IMM_W-1:0];
        is_imm = (op_f[5:3] == LPD_OP_IMM_HI);
        is_idx = (op_f == LPD_OP_IDX) && (instr[5:3] == LPD_FN_IDX_HI);
    end

    always_comb begin
        rec = '0;
        if (is_imm || is_idx) begin
            rec.valid = 1'b1;
            rec.mode  = is_idx ? MODE_REG_REG : MODE_REG_IMM;
            if (base_f == SP_NUM) begin
                rec.base = BASE_SP;
            end else if (base_f == GP_NUM) begin
                rec.base = BASE_GP;
            end else begin
                rec.base = BASE_OTHER;
            end
            if (is_idx) begin
                rec.offset = '0;
            end else begin
                rec.offset = {{(LPD_OFS_W-LPD_IMM_W){imm_f[LPD_IMM_W-1]}}, imm_f};
            end
        end
    end

endmodule

// File: rtl/lpd_ctrl.sv
module lpd_ctrl
    import lpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fill_valid,
    output logic wr_en
);

    lpd_state_e state_q;
    lpd_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = fill_valid ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = fill_valid ? ST_WRITE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  wr_en = 1'b0;
            ST_WRITE: wr_en = 1'b1;
            default:  wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpd_rec_store.sv
module lpd_rec_store
    import lpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture,
    input  lpd_rec_t rec_d,
    output lpd_rec_t rec_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (capture) begin
            rec_q <= rec_d;
        end
    end

endmodule

// File: rtl/lpd_fill_predecoder.sv
module lpd_fill_predecoder
    import lpd_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int SP_REG = 29,
    parameter int GP_REG = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_valid,
    input  logic [SLOTS*LPD_IW-1:0]  fill_line,
    output logic                     rec_we,
    output logic [SLOTS-1:0]         rec_valid,
    output logic [SLOTS-1:0]         rec_mode,
    output logic [SLOTS*2-1:0]       rec_btype,
    output logic [SLOTS*LPD_OFS_W-1:0] rec_offset
);

    lpd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .wr_en      (rec_we)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        lpd_rec_t rec_c;
        lpd_rec_t rec_r;

        lpd_slot_decode #(
            .SP_REG (SP_REG),
            .GP_REG (GP_REG)
        ) u_dec (
            .instr (fill_line[s*LPD_IW +: LPD_IW]),
            .rec   (rec_c)
        );

        lpd_rec_store u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (fill_valid),
            .rec_d   (rec_c),
            .rec_q   (rec_r)
        );

        assign rec_valid[s]                       = rec_r.valid;
        assign rec_mode[s]                        = rec_r.mode;
        assign rec_btype[s*2 +: 2]                = rec_r.base;
        assign rec_offset[s*LPD_OFS_W +: LPD_OFS_W] = rec_r.offset;
    end

endmodule

// File: rtl/lpd_fill_predecoder_chk.sv
module lpd_fill_predecoder_chk
    import lpd_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fill_valid,
    input logic [SLOTS*LPD_IW-1:0]    fill_line,
    input logic                       rec_we,
    input logic [SLOTS-1:0]           rec_valid,
    input logic [SLOTS-1:0]           rec_mode,
    input logic [SLOTS*2-1:0]         rec_btype,
    input logic [SLOTS*LPD_OFS_W-1:0] rec_offset
);

    logic unused_line;
    assign unused_line = ^fill_line;

    a_r2_we_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> rec_we);

    a_r2_we_only_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !rec_we);

    a_r8_hold_without_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> ($stable(rec_valid) && $stable(rec_mode)
                         && $stable(rec_btype) && $stable(rec_offset)));

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        a_r7_empty_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !rec_valid[s] |-> (!rec_mode[s] && rec_btype[s*2 +: 2] == 2'b00
                               && rec_offset[s*LPD_OFS_W +: LPD_OFS_W] == '0));

        a_r4_indexed_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
            (rec_valid[s] && rec_mode[s]) |-> (rec_offset[s*LPD_OFS_W +: LPD_OFS_W] == '0));

        a_r5_no_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
            rec_btype[s*2 +: 2] != 2'b11);

        a_r6_offset_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
            (rec_valid[s] && !rec_mode[s]) |->
            (rec_offset[s*LPD_OFS_W+LPD_IMM_W-1 +: (LPD_OFS_W-LPD_IMM_W+1)] == '0
             || rec_offset[s*LPD_OFS_W+LPD_IMM_W-1 +: (LPD_OFS_W-LPD_IMM_W+1)] == '1));
    end

endmodule

bind lpd_fill_predecoder lpd_fill_predecoder_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/tb_lpd_fill_predecoder.sv
module tb_lpd_fill_predecoder;

    localparam int SLOTS = 4;
    localparam int W     = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 fill_valid = 1'b0;
    logic [SLOTS*W-1:0]   fill_line = '0;
    logic                 rec_we;
    logic [SLOTS-1:0]     rec_valid;
    logic [SLOTS-1:0]     rec_mode;
    logic [SLOTS*2-1:0]   rec_btype;
    logic [SLOTS*W-1:0]   rec_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    lpd_fill_predecoder #(.SLOTS(SLOTS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .rec_we     (rec_we),
        .rec_valid  (rec_valid),
        .rec_mode   (rec_mode),
        .rec_btype  (rec_btype),
        .rec_offset (rec_offset)
    );

    // expected record {valid, mode, class[1:0], offset[31:0]} from the requirements
    function automatic logic [35:0] model(input logic [31:0] ins);
        int op, fn, base;
        logic v, m;
        logic [1:0] bt;
        logic [31:0] off;
        op   = int'(ins[31:26]);
        fn   = int'(ins[5:0]);
        base = int'(ins[25:21]);
        v = 1'b0; m = 1'b0; bt = 2'd0; off = 32'd0;
        if (op / 8 == 4) begin                 // R3
            v = 1'b1;
            off = 32'(int'(ins[15:0]) - (ins[15] ? 65536 : 0)); // R6
        end else if (op == 31 && fn / 8 == 1) begin // R4
            v = 1'b1; m = 1'b1;
        end
        if (v) bt = (base == 29) ? 2'd1 : (base == 28) ? 2'd2 : 2'd0; // R5
        return {v, m, bt, off};
    endfunction

    function automatic logic [35:0] got(input int s);
        return {rec_valid[s], rec_mode[s], rec_btype[s*2 +: 2], rec_offset[s*W +: W]};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one fill, check write enable and records, then one idle cycle with junk
    task automatic do_fill(input logic [SLOTS*W-1:0] line, input string req);
        logic [35:0] exp_r [SLOTS];
        for (int s = 0; s < SLOTS; s++) exp_r[s] = model(line[s*W +: W]);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line  = line;
        @(negedge clk);
        fill_valid = 1'b0;
        fill_line  = ~line;
        chk("R2", {35'd0, rec_we}, 36'd1);
        for (int s = 0; s < SLOTS; s++) chk(req, got(s), exp_r[s]);
        @(negedge clk);
        chk("R2", {35'd0, rec_we}, 36'd0);
        for (int s = 0; s < SLOTS; s++) chk("R8", got(s), exp_r[s]);
    endtask

    function automatic logic [31:0] filler(input int k);
        return {6'h0B, 5'(k), 5'(k * 3), 16'(k * 4099 + 7)};
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {35'd0, rec_we}, 36'd0);
        for (int s = 0; s < SLOTS; s++) chk("R1", got(s), 36'd0);
        rst_n = 1'b1;

        // opcode x base sweep; load rotates through slots, others non-loads (R3 R5 R7 R9)
        for (int op = 0; op < 64; op++) begin
            for (int b = 0; b < 32; b++) begin
                logic [SLOTS*W-1:0] ln;
                int slot;
                slot = (op + b) % SLOTS;
                for (int s = 0; s < SLOTS; s++) ln[s*W +: W] = filler(op * 32 + b + s);
                ln[slot*W +: W] = {6'(op), 5'(b), 5'(b ^ 5'd7), 16'(op * 1237 + b * 977 + 32768 * (b % 2))};
                do_fill(ln, "R3_R5_R7");
            end
        end

        // function-code sweep under the indexed opcode, low half non-zero (R4)
        for (int fn = 0; fn < 64; fn++) begin
            logic [SLOTS*W-1:0] ln;
            for (int s = 0; s < SLOTS; s++)
                ln[s*W +: W] = {6'h1F, 5'(27 + s), 5'(fn), 5'(s + 1), 5'd3, 6'(fn)};
            do_fill(ln, "R4");
        end

        // back-to-back fills keep write enable high (R2), second values win
        begin
            logic [SLOTS*W-1:0] a, b2;
            for (int s = 0; s < SLOTS; s++) begin
                a[s*W +: W]  = {6'h23, 5'd29, 5'd1, 16'h8001 + 16'(s)};
                b2[s*W +: W] = {6'h20, 5'd28, 5'd2, 16'h0123 + 16'(s)};
            end
            @(negedge clk);
            fill_valid = 1'b1; fill_line = a;
            @(negedge clk);
            fill_line = b2;
            chk("R2", {35'd0, rec_we}, 36'd1);
            for (int s = 0; s < SLOTS; s++) chk("R6", got(s), model(a[s*W +: W]));
            @(negedge clk);
            fill_valid = 1'b0; fill_line = '1;
            chk("R2", {35'd0, rec_we}, 36'd1);
            for (int s = 0; s < SLOTS; s++) chk("R9", got(s), model(b2[s*W +: W]));
            repeat (5) begin
                @(negedge clk);
                fill_line = fill_line ^ {SLOTS{32'h8C00_FFFF}};
                chk("R2", {35'd0, rec_we}, 36'd0);
                for (int s = 0; s < SLOTS; s++) chk("R8", got(s), model(b2[s*W +: W]));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule